// File: doc/BRIEF.md
# Audio Clock Master for a Host and a Codec

This block is the clock master of an audio link in which a host processor and a codec exchange serial sample data directly. It takes two free-running oscillators, one for the 44.1 kHz sample-rate family and one for the 48 kHz family, and switches between them without glitches. From the chosen oscillator it derives a master clock for the codec, plus a bit clock and a frame clock for each of the two destinations. The serial data lines do not pass through the block.

All control arrives on asynchronous general-purpose pins: oscillator choice, a two-bit rate code, a run enable and a start lag in frames. On enable, the codec clocks start first. The host clocks join at a frame boundary after the programmed number of whole frames, in exact phase with the codec clocks. A lag of zero starts both together. If the oscillator or rate pins change while running, every output is first driven low. The clock source is then swapped, and the clocks restart with the new settings.

Top module: `i2s_clk_master`

## Requirements
- R1: While reset is asserted, and afterwards until the enable pin is high, every clock output is low.
- R2: When running, the master clock period is exactly two periods of the selected oscillator.
- R3: Select code 0 sources all outputs from `oscA`, code 1 from `oscB`.
- R4: Rate code k (0 to 3) gives a bit clock period of 2^(k+1) periods of the selected oscillator.
- R5: The frame clock period is 64 bit-clock periods. It changes only when the bit clock falls. It is low for the first 32 bit periods of a frame, so its first rise comes 31.5 bit periods after the first bit-clock rise.
- R6: With the enable pin low, every clock output is driven low and stays low.
- R7: The first host bit-clock rise comes exactly lag x 64 bit periods after the first codec bit-clock rise. A lag of 0 gives a simultaneous start.
- R8: The host clocks start at a frame boundary. From then on, host bit and frame clocks equal the codec ones at every instant.
- R9: After a change of select or rate while enabled, outputs go low, then resume with the new settings. No output pulse is shorter than one period of the faster oscillator.
- R10: The clock source never changes while the clocks are running.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| oscA | input | 1 | Oscillator for the 44.1 kHz family |
| oscB | input | 1 | Oscillator for the 48 kHz family |
| rstN | input | 1 | Asynchronous active-low reset |
| selPin | input | 1 | Oscillator choice, 0 = oscA, 1 = oscB (async) |
| ratePin | input | RATE_W | Rate code k, bit clock = osc / 2^(k+1) (async) |
| enPin | input | 1 | Run enable for all clock outputs (async) |
| lagPin | input | LAG_W | Host start lag in whole frames (async) |
| mclk | output | 1 | Master clock to the codec |
| codecBclk | output | 1 | Bit clock to the codec |
| codecLrclk | output | 1 | Frame clock to the codec |
| hostBclk | output | 1 | Bit clock to the host |
| hostLrclk | output | 1 | Frame clock to the host |

## Verification
A wrong divider limit or a bit counter off by one shows up within one frame as a wrong bit-clock period or a misplaced frame-clock rise relative to the first bit-clock rise. A host-enable flag set at the wrong moment shows as a host start displaced by a multiple of the frame period, or as host and codec clocks that differ inside the first frame after the host starts. A bad clock-swap handshake shows as a pulse narrower than one oscillator period on an output during the swap. A state machine that does not leave its running state shows as outputs still toggling after the enable pin falls.

// File: rtl/i2s_clk_pkg.sv
`timescale 1ns/10ps
package i2s_clk_pkg;

  typedef enum logic [1:0] {
    ST_OFF    = 2'd0,
    ST_SETTLE = 2'd1,
    ST_RUN    = 2'd2
  } clk_state_t;

  // strobes from control to datapath
  typedef struct packed {
    logic run;     // counters running, codec clocks live
    logic hostEn;  // host copies follow the codec clocks
  } clk_cmd_t;

endpackage

// File: rtl/i2s_pin_sync.sv
`timescale 1ns/10ps
module i2s_pin_sync #(
  parameter int W = 1
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic [W-1:0] din,
  output logic [W-1:0] dout
);
  logic [W-1:0] stage1;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      stage1 <= '0;
      dout   <= '0;
    end else begin
      stage1 <= din;
      dout   <= stage1;
    end
  end
endmodule

// File: rtl/i2s_src_switch.sv
`timescale 1ns/10ps
module i2s_src_switch (
  input  logic oscA,
  input  logic oscB,
  input  logic rstN,
  input  logic selB,
  output logic clkOut
);
  logic aReq, aGate, bReq, bGate;

  // each side asks for the clock only once the other side has released it
  always_ff @(posedge oscA or negedge rstN)
    if (!rstN) aReq <= 1'b0;
    else       aReq <= !selB && !bGate;

  always_ff @(negedge oscA or negedge rstN)
    if (!rstN) aGate <= 1'b0;
    else       aGate <= aReq;

  always_ff @(posedge oscB or negedge rstN)
    if (!rstN) bReq <= 1'b0;
    else       bReq <= selB && !aGate;

  always_ff @(negedge oscB or negedge rstN)
    if (!rstN) bGate <= 1'b0;
    else       bGate <= bReq;

  // gates change only while their oscillator is low
  assign clkOut = (oscA & aGate) | (oscB & bGate);
endmodule

// File: rtl/i2s_clk_ctrl.sv
`timescale 1ns/10ps
module i2s_clk_ctrl
  import i2s_clk_pkg::*;
#(
  parameter int RATE_W     = 2,
  parameter int LAG_W      = 3,
  parameter int SETTLE_CYC = 16
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              selS,
  input  logic [RATE_W-1:0] rateS,
  input  logic              enS,
  input  logic [LAG_W-1:0]  lagS,
  input  logic              frameEnd,
  output clk_cmd_t          cmd,
  output logic              appSel,
  output logic [RATE_W-1:0] appRate
);
  localparam int SC_W = (SETTLE_CYC > 1) ? $clog2(SETTLE_CYC) : 1;

  clk_state_t       state;
  logic [SC_W-1:0]  settleCnt;
  logic [LAG_W-1:0] lagQ;
  logic [LAG_W-1:0] frameCnt;
  logic             hostEn;
  logic             changed;

  assign changed = (selS != appSel) || (rateS != appRate);

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state     <= ST_OFF;
      appSel    <= 1'b0;
      appRate   <= '0;
      lagQ      <= '0;
      settleCnt <= '0;
      frameCnt  <= '0;
      hostEn    <= 1'b0;
    end else begin
      case (state)
        ST_OFF: begin
          hostEn <= 1'b0;
          if (enS) begin
            // outputs are already low here, so the source may move
            appSel    <= selS;
            appRate   <= rateS;
            lagQ      <= lagS;
            settleCnt <= '0;
            state     <= ST_SETTLE;
          end
        end
        ST_SETTLE: begin
          if (!enS || changed) state <= ST_OFF;
          else if (settleCnt == SC_W'(SETTLE_CYC - 1)) begin
            state    <= ST_RUN;
            frameCnt <= '0;
            hostEn   <= (lagQ == '0);
          end else settleCnt <= settleCnt + 1'b1;
        end
        ST_RUN: begin
          if (!enS || changed) begin
            state  <= ST_OFF;
            hostEn <= 1'b0;
          end else if (frameEnd && !hostEn) begin
            frameCnt <= frameCnt + 1'b1;
            if ({1'b0, frameCnt} + 1'b1 == {1'b0, lagQ}) hostEn <= 1'b1;
          end
        end
        default: state <= ST_OFF;
      endcase
    end
  end

  assign cmd.run    = (state == ST_RUN);
  assign cmd.hostEn = hostEn;
endmodule

// File: rtl/i2s_clk_dp.sv
`timescale 1ns/10ps
module i2s_clk_dp
  import i2s_clk_pkg::*;
#(
  parameter int RATE_W         = 2,
  parameter int BCLK_PER_FRAME = 64   // power of two
) (
  input  logic              clk,
  input  logic              rstN,
  input  clk_cmd_t          cmd,
  input  logic [RATE_W-1:0] rate,
  output logic              frameEnd,
  output logic              mclk,
  output logic              codecBclk,
  output logic              codecLrclk,
  output logic              hostBclk,
  output logic              hostLrclk
);
  localparam int DIV_W = (2 ** RATE_W) - 1;
  localparam int BIT_W = $clog2(BCLK_PER_FRAME);

  logic [DIV_W-1:0] divCnt, lim;
  logic [DIV_W:0]   limWide;
  logic [BIT_W-1:0] bitCnt, bitNext;
  logic             halfDone, fallNow, bclkNext, lrNext;

  // half bit period = 2^rate core cycles
  assign limWide  = ((DIV_W+1)'(1) << rate) - 1'b1;
  assign lim      = limWide[DIV_W-1:0];
  assign halfDone = (divCnt == lim);
  assign fallNow  = halfDone && codecBclk;
  assign bitNext  = bitCnt + 1'b1;
  assign bclkNext = halfDone ? ~codecBclk : codecBclk;
  assign lrNext   = fallNow ? bitNext[BIT_W-1] : codecLrclk;
  assign frameEnd = cmd.run && fallNow && (bitCnt == BIT_W'(BCLK_PER_FRAME - 1));

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      divCnt <= '0; bitCnt <= '0; mclk <= 1'b0;
      codecBclk <= 1'b0; codecLrclk <= 1'b0;
      hostBclk  <= 1'b0; hostLrclk  <= 1'b0;
    end else if (!cmd.run) begin
      divCnt <= '0; bitCnt <= '0; mclk <= 1'b0;
      codecBclk <= 1'b0; codecLrclk <= 1'b0;
      hostBclk  <= 1'b0; hostLrclk  <= 1'b0;
    end else begin
      mclk       <= ~mclk;
      divCnt     <= halfDone ? '0 : divCnt + 1'b1;
      codecBclk  <= bclkNext;
      codecLrclk <= lrNext;
      if (fallNow) bitCnt <= bitNext;
      hostBclk   <= cmd.hostEn & bclkNext;
      hostLrclk  <= cmd.hostEn & lrNext;
    end
  end
endmodule

// File: rtl/i2s_clk_master.sv
`timescale 1ns/10ps
module i2s_clk_master
  import i2s_clk_pkg::*;
#(
  parameter int RATE_W         = 2,
  parameter int LAG_W          = 3,
  parameter int SETTLE_CYC     = 16,
  parameter int BCLK_PER_FRAME = 64
) (
  input  logic              oscA,
  input  logic              oscB,
  input  logic              rstN,
  input  logic              selPin,
  input  logic [RATE_W-1:0] ratePin,
  input  logic              enPin,
  input  logic [LAG_W-1:0]  lagPin,
  output logic              mclk,
  output logic              codecBclk,
  output logic              codecLrclk,
  output logic              hostBclk,
  output logic              hostLrclk
);
  localparam int PIN_W = 2 + RATE_W + LAG_W;

  logic              coreClk, appSel, frameEnd;
  logic [RATE_W-1:0] appRate;
  logic [PIN_W-1:0]  pinSync;
  clk_cmd_t          cmd;

  i2s_src_switch i_switch (
    .oscA(oscA), .oscB(oscB), .rstN(rstN), .selB(appSel), .clkOut(coreClk)
  );

  i2s_pin_sync #(.W(PIN_W)) i_sync (
    .clk(coreClk), .rstN(rstN),
    .din({lagPin, enPin, ratePin, selPin}), .dout(pinSync)
  );

  i2s_clk_ctrl #(.RATE_W(RATE_W), .LAG_W(LAG_W), .SETTLE_CYC(SETTLE_CYC)) i_ctrl (
    .clk(coreClk), .rstN(rstN),
    .selS(pinSync[0]),
    .rateS(pinSync[RATE_W:1]),
    .enS(pinSync[RATE_W+1]),
    .lagS(pinSync[PIN_W-1:RATE_W+2]),
    .frameEnd(frameEnd), .cmd(cmd), .appSel(appSel), .appRate(appRate)
  );

  i2s_clk_dp #(.RATE_W(RATE_W), .BCLK_PER_FRAME(BCLK_PER_FRAME)) i_dp (
    .clk(coreClk), .rstN(rstN), .cmd(cmd), .rate(appRate),
    .frameEnd(frameEnd), .mclk(mclk),
    .codecBclk(codecBclk), .codecLrclk(codecLrclk),
    .hostBclk(hostBclk), .hostLrclk(hostLrclk)
  );
endmodule

// File: rtl/i2s_clk_master_chk.sv
`timescale 1ns/10ps
module i2s_clk_master_chk (
  input logic coreClk,
  input logic rstN,
  input logic run,
  input logic hostEn,
  input logic appSel,
  input logic mclk,
  input logic codecBclk,
  input logic codecLrclk,
  input logic hostBclk,
  input logic hostLrclk
);
  a_r6_off_low: assert property (@(posedge coreClk) disable iff (!rstN)
    !run |=> (!mclk && !codecBclk && !codecLrclk && !hostBclk && !hostLrclk));

  a_r5_lr_on_fall: assert property (@(posedge coreClk) disable iff (!rstN)
    ($past(run) && (codecLrclk != $past(codecLrclk))) |-> $fell(codecBclk));

  a_r8_host_match: assert property (@(posedge coreClk) disable iff (!rstN)
    $past(hostEn) |-> (hostBclk == codecBclk && hostLrclk == codecLrclk));

  a_r8_host_boundary: assert property (@(posedge coreClk) disable iff (!rstN)
    $rose(hostEn) |-> (!codecBclk && !codecLrclk));

  a_r10_src_stable: assert property (@(posedge coreClk) disable iff (!rstN)
    ($past(run) && run) |-> $stable(appSel));
endmodule

bind i2s_clk_master i2s_clk_master_chk u_chk (
  .coreClk(coreClk), .rstN(rstN), .run(cmd.run), .hostEn(cmd.hostEn),
  .appSel(appSel), .mclk(mclk), .codecBclk(codecBclk), .codecLrclk(codecLrclk),
  .hostBclk(hostBclk), .hostLrclk(hostLrclk)
);

// File: tb/test_i2s_clk_master.sv
`timescale 1ns/10ps
module test_i2s_clk_master;
  logic oscA = 1'b0, oscB = 1'b0, rstN = 1'b0;
  logic selPin = 1'b0, enPin = 1'b0;
  logic [1:0] ratePin = '0;
  logic [2:0] lagPin = '0;
  logic mclk, codecBclk, codecLrclk, hostBclk, hostLrclk;

  always #2.5 oscA = ~oscA;   // 200 MHz
  always #2.7 oscB = ~oscB;

  i2s_clk_master i_i2s_clk_master (
    .oscA(oscA), .oscB(oscB), .rstN(rstN), .selPin(selPin), .ratePin(ratePin),
    .enPin(enPin), .lagPin(lagPin), .mclk(mclk), .codecBclk(codecBclk),
    .codecLrclk(codecLrclk), .hostBclk(hostBclk), .hostLrclk(hostLrclk)
  );

  int  nChk = 0, nFail = 0;
  bit  done = 0;
  bit  armed = 0, gotC = 0, gotH = 0, gotL = 0;
  real tC, tH, tL;
  real minW = 1.0e9;
  real lastM = -1.0, lastCB = -1.0, lastHB = -1.0;

  always @(posedge codecBclk) if (armed && !gotC) begin gotC = 1; tC = $realtime; end
  always @(posedge hostBclk)  if (armed && !gotH) begin gotH = 1; tH = $realtime; end
  always @(posedge codecLrclk) if (armed && !gotL) begin gotL = 1; tL = $realtime; end

  // pulse width monitors for R9
  always @(mclk) begin
    if (lastM >= 0.0 && $realtime - lastM < minW) minW = $realtime - lastM;
    lastM = $realtime;
  end
  always @(codecBclk) begin
    if (lastCB >= 0.0 && $realtime - lastCB < minW) minW = $realtime - lastCB;
    lastCB = $realtime;
  end
  always @(hostBclk) begin
    if (lastHB >= 0.0 && $realtime - lastHB < minW) minW = $realtime - lastHB;
    lastHB = $realtime;
  end

  function automatic bit near(real a, real b);
    return (a - b < 0.05) && (b - a < 0.05);
  endfunction
  function automatic real oscPer(bit s);
    return s ? 5.4 : 5.0;
  endfunction
  function automatic real bclkPer(bit s, int r);
    return 2.0 * real'(1 << r) * oscPer(s);
  endfunction

  task automatic chk(bit ok, string tag, real act, real exp);
    nChk++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s actual=%0.2f expected=%0.2f", tag, act, exp);
    end
  endtask

  task automatic allLow(string tag, int span);
    int bad = 0;
    #0.05;
    for (int i = 0; i < span; i++) begin
      #1;
      if (mclk || codecBclk || codecLrclk || hostBclk || hostLrclk) bad++;
    end
    chk(bad == 0, tag, real'(bad), 0.0);
  endtask

  task automatic perOf(int which, output real p);
    real t0;
    case (which)
      0: begin @(posedge codecBclk);  t0 = $realtime; @(posedge codecBclk);  end
      1: begin @(posedge mclk);       t0 = $realtime; @(posedge mclk);       end
      default: begin @(posedge codecLrclk); t0 = $realtime; @(posedge codecLrclk); end
    endcase
    p = $realtime - t0;
  endtask

  task automatic scenario(bit s, int r, int lag);
    real bp, p;
    int  mism = 0;
    enPin = 0;
    #300;
    selPin = s; ratePin = 2'(r); lagPin = 3'(lag);
    gotC = 0; gotH = 0; gotL = 0; armed = 1;
    enPin = 1;
    wait (gotC && gotH && gotL);
    armed = 0;
    bp = bclkPer(s, r);
    chk(near(tL - tC, 31.5 * bp), "R5 frame clock first rise offset", tL - tC, 31.5 * bp);
    chk(near(tH - tC, real'(lag) * 64.0 * bp), "R7 host start lag", tH - tC, real'(lag) * 64.0 * bp);
    perOf(0, p); chk(near(p, bp), "R3/R4 bit clock period", p, bp);
    perOf(1, p); chk(near(p, 2.0 * oscPer(s)), "R2 master clock period", p, 2.0 * oscPer(s));
    perOf(2, p); chk(near(p, 64.0 * bp), "R5 frame clock period", p, 64.0 * bp);
    #0.05;
    for (int i = 0; i < 1500; i++) begin
      #1;
      if (hostBclk !== codecBclk || hostLrclk !== codecLrclk) mism++;
    end
    chk(mism == 0, "R8 host equals codec", real'(mism), 0.0);
  endtask

  initial begin
    int unsigned sd;
    real p;
    sd = $urandom(32'd4242);
    #20.3;
    allLow("R1 outputs low in reset", 15);
    rstN = 1;
    #100;
    allLow("R1 outputs low before enable", 200);

    // directed corners
    scenario(0, 0, 0);
    scenario(1, 0, 0);
    scenario(0, 3, 2);
    scenario(1, 2, 1);
    scenario(0, 1, 7);
    // random mix
    for (int k = 0; k < 4; k++)
      scenario(1'($urandom % 2), int'($urandom % 4), int'($urandom % 3));

    // R6: disable forces all outputs low
    enPin = 0;
    #100;
    allLow("R6 outputs low when disabled", 400);

    // R9: hot change of source and rate
    scenario(0, 1, 0);
    selPin = 1; ratePin = 2'd2;
    #2000;
    perOf(0, p); chk(near(p, bclkPer(1, 2)), "R9 bit clock after switch", p, bclkPer(1, 2));
    perOf(1, p); chk(near(p, 10.8), "R9 master clock after switch", p, 10.8);
    selPin = 0; ratePin = 2'd0;
    #2000;
    perOf(0, p); chk(near(p, bclkPer(0, 0)), "R9 bit clock after switch back", p, bclkPer(0, 0));
    chk(minW > 4.95, "R9 no runt pulse", minW, 5.0);

    if (!done) begin
      done = 1;
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end

  initial begin
    #900000;
    if (!done) begin
      done = 1;
      nChk++; nFail++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("%0d/%0d checks passed", nChk - nFail, nChk);
      $finish;
    end
  end
endmodule